// File: doc/BRIEF.md
# Test Access Port Instruction Controller

This block is the serial test port controller of a memory device. It follows the two serial controls, TMS and TDI, through the sixteen-state test controller. It keeps a three-bit instruction and decodes it. From that decode it picks which data register is placed between TDI and TDO.

Two data registers live inside the block: a 32-bit identification register and a one-bit bypass stage. The boundary scan chain sits outside the block. Its serial output comes back in on `bsr_so`, and the chain cells use the capture, shift and update strobes that the block drives out.

The block also asks the functional output drivers to let go of the bus while a high-impedance sampling instruction is in force. All pins are plain level signals clocked by `tck`. No stream handshake applies, because the serial port has no back-pressure.

After an asynchronous reset, or after a pass through the reset state, the identification instruction is in force. The serial output is not a true tri-state pin here. `tdo_en` marks when the pad should drive `tdo`, and the pad is high impedance whenever `tdo_en` is low.

Top module: `tap_instr_ctrl`

## Requirements
- R1: While `trst_n` is low, and from the first rising TCK edge spent in Test-Logic-Reset, the current instruction is IDCODE (code 001): `inst_idcode`=1, `out_bus_en`=1 and `tdo_en`=0.
- R2: Five consecutive rising edges with TMS high bring the controller into Test-Logic-Reset from any state. The IDCODE instruction is then restored as in R1.
- R3: In Capture-IR the instruction shift stage loads 001. Shifting in Shift-IR presents bit 0 first on TDO and enters TDI at bit 2.
- R4: The current instruction, and every flag decoded from it, changes only on the rising edge that leaves Update-IR (or in reset). While Shift-IR, Exit1-IR and Update-IR are in progress, the previous instruction stays in force.
- R5: Under IDCODE, a Shift-DR scan presents the 32-bit ID value least significant bit first. That bit is always 1.
- R6: Under BYPASS (code 111), the one-bit bypass stage captures 0 in Capture-DR. Each TDI bit appears on TDO one shift later.
- R7: The unassigned codes 011, 101 and 110 raise `inst_bypass` and behave exactly like BYPASS.
- R8: Under SAMPLE Z (code 010), `inst_samplez`=1, `sel_bsr`=1 and `out_bus_en`=0. These hold through any number of DR scans until another instruction is committed at Update-IR. In Shift-DR, TDO follows `bsr_so`.
- R9: Under EXTEST (code 000) and SAMPLE/PRELOAD (code 100), the boundary chain is selected (`sel_bsr`=1), the matching flag is raised and `out_bus_en`=1.
- R10: TDO and `tdo_en` change only on the falling edge of TCK. `tdo_en` is 1 only in the Shift-IR and Shift-DR states.
- R11: `capture_dr`, `shift_dr` and `update_dr` are each high exactly while the controller is in Capture-DR, Shift-DR and Update-DR respectively.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in, sampled on rising TCK |
| bsr_so | input | 1 | Serial output of the external boundary chain |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| tdo_en | output | 1 | Pad drive enable for tdo (low = high impedance) |
| capture_dr | output | 1 | Controller is in Capture-DR |
| shift_dr | output | 1 | Controller is in Shift-DR |
| update_dr | output | 1 | Controller is in Update-DR |
| sel_bsr | output | 1 | Boundary chain is the selected data path |
| inst_extest | output | 1 | EXTEST in force |
| inst_sample | output | 1 | SAMPLE/PRELOAD in force |
| inst_samplez | output | 1 | SAMPLE Z in force |
| inst_idcode | output | 1 | IDCODE in force |
| inst_bypass | output | 1 | BYPASS or an unassigned code in force |
| out_bus_en | output | 1 | Functional output bus may drive (low while SAMPLE Z is in force) |

## Verification
The bench keeps the default 32-bit identification width and sets `ID_VALUE` to 32'h5A3C_96E1. With that value, both polarities appear in each nibble, so a scan that is swapped, short or rotated shows up as a bit error. Every instruction code, including all three unassigned ones, is loaded through real IR scans. The release of the output bus is watched across an intervening DR scan and across a TMS-driven return to reset.

// File: rtl/tap_pkg.sv
package tap_pkg;

  localparam int unsigned INSTR_W = 3;

  localparam logic [INSTR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [INSTR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [INSTR_W-1:0] OP_SAMPLEZ = 3'b010;
  localparam logic [INSTR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [INSTR_W-1:0] OP_BYPASS  = 3'b111;

  // value parked in the instruction shift stage at Capture-IR
  localparam logic [INSTR_W-1:0] IR_CAPTURE = 3'b001;

  typedef enum logic [3:0] {
    ST_RESET, ST_IDLE,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef struct packed {
    logic extest;
    logic idcode;
    logic samplez;
    logic sample;
    logic bypass;
  } instr_flags_t;

  function automatic instr_flags_t decode_op(logic [INSTR_W-1:0] op);
    instr_flags_t f;
    f = '0;
    case (op)
      OP_EXTEST:  f.extest  = 1'b1;
      OP_IDCODE:  f.idcode  = 1'b1;
      OP_SAMPLEZ: f.samplez = 1'b1;
      OP_SAMPLE:  f.sample  = 1'b1;
      default:    f.bypass  = 1'b1;
    endcase
    return f;
  endfunction

  function automatic tap_state_e step_state(tap_state_e s, logic m);
    tap_state_e n;
    case (s)
      ST_RESET:  n = m ? ST_RESET  : ST_IDLE;
      ST_IDLE:   n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: n = m ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: n = m ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  n = m ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: n = m ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: n = m ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: n = m ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: n = m ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: n = m ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: n = m ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  n = m ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: n = m ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: n = m ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: n = m ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: n = m ? ST_SEL_DR : ST_IDLE;
      default:   n = ST_RESET;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/tap_state_fsm.sv
module tap_state_fsm
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= step_state(state, tms);
  end

  // run of consecutive TMS-high edges, saturating at five
  logic [2:0] ones_q;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)          ones_q <= '0;
    else if (!tms)        ones_q <= '0;
    else if (ones_q != 5) ones_q <= ones_q + 3'd1;
  end

  // R2
  tms_reset_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ones_q >= 3'd4 && tms) |=> state == ST_RESET);

  // R11
  shift_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_SH_DR && !tms) |=> state == ST_SH_DR);

endmodule

// File: rtl/tap_instr_reg.sv
module tap_instr_reg
  import tap_pkg::*;
(
  input  logic               tck,
  input  logic               trst_n,
  input  tap_state_e         state,
  input  logic               tdi,
  output logic               ir_so,
  output logic [INSTR_W-1:0] cur
);

  logic [INSTR_W-1:0] sr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr <= IR_CAPTURE;
    end else begin
      case (state)
        ST_CAP_IR: sr <= IR_CAPTURE;
        ST_SH_IR:  sr <= {tdi, sr[INSTR_W-1:1]};
        default:   sr <= sr;
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 cur <= OP_IDCODE;
    else if (state == ST_RESET)  cur <= OP_IDCODE;
    else if (state == ST_UPD_IR) cur <= sr;
  end

  assign ir_so = sr[0];

  // R3
  ir_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    state == ST_CAP_IR |=> sr == IR_CAPTURE);

  // R4
  ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state != ST_UPD_IR && state != ST_RESET) |=> $stable(cur));

endmodule

// File: rtl/tap_data_path.sv
module tap_data_path
  import tap_pkg::*;
#(
  parameter int unsigned     ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
  input  logic       tck,
  input  logic       trst_n,
  input  tap_state_e state,
  input  logic       tdi,
  input  logic       sel_id,
  input  logic       sel_byp,
  input  logic       sel_bsr,
  input  logic       ir_so,
  input  logic       bsr_so,
  output logic       tdo,
  output logic       tdo_en
);

  localparam logic [ID_W-1:0] ID_CAP = {ID_VALUE[ID_W-1:1], 1'b1};

  logic [ID_W-1:0] id_sr;
  logic            byp_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      id_sr <= ID_CAP;
      byp_q <= 1'b0;
    end else begin
      if (state == ST_CAP_DR) begin
        if (sel_id)  id_sr <= ID_CAP;
        if (sel_byp) byp_q <= 1'b0;
      end else if (state == ST_SH_DR) begin
        if (sel_id)  id_sr <= {tdi, id_sr[ID_W-1:1]};
        if (sel_byp) byp_q <= tdi;
      end
    end
  end

  logic dr_bit;
  always_comb begin
    if (sel_id)       dr_bit = id_sr[0];
    else if (sel_bsr) dr_bit = bsr_so;
    else              dr_bit = byp_q;
  end

  logic in_shift_ir, in_shift_dr;
  assign in_shift_ir = (state == ST_SH_IR);
  assign in_shift_dr = (state == ST_SH_DR);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_en <= 1'b0;
    end else begin
      tdo_en <= in_shift_ir | in_shift_dr;
      if (in_shift_ir)      tdo <= ir_so;
      else if (in_shift_dr) tdo <= dr_bit;
    end
  end

  // R6
  byp_capture_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_DR && sel_byp) |=> !byp_q);

  // R10
  tdo_en_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en |-> (state == ST_SH_DR || state == ST_SH_IR));

  // R10
  tdo_edge_chk: assert property (@(posedge tck) disable iff (!trst_n)
    state == ST_IDLE |=> !tdo_en);

endmodule

// File: rtl/tap_instr_ctrl.sv
module tap_instr_ctrl
  import tap_pkg::*;
#(
  parameter int unsigned     ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
) (
  input  logic tck,
  input  logic trst_n,
  input  logic tms,
  input  logic tdi,
  input  logic bsr_so,
  output logic tdo,
  output logic tdo_en,
  output logic capture_dr,
  output logic shift_dr,
  output logic update_dr,
  output logic sel_bsr,
  output logic inst_extest,
  output logic inst_sample,
  output logic inst_samplez,
  output logic inst_idcode,
  output logic inst_bypass,
  output logic out_bus_en
);

  tap_state_e         state;
  logic [INSTR_W-1:0] cur;
  logic               ir_so;
  instr_flags_t       flags;

  tap_state_fsm u_fsm (
    .tck    (tck),
    .trst_n (trst_n),
    .tms    (tms),
    .state  (state)
  );

  tap_instr_reg u_ir (
    .tck    (tck),
    .trst_n (trst_n),
    .state  (state),
    .tdi    (tdi),
    .ir_so  (ir_so),
    .cur    (cur)
  );

  assign flags = decode_op(cur);

  tap_data_path #(
    .ID_W     (ID_W),
    .ID_VALUE (ID_VALUE)
  ) u_dp (
    .tck     (tck),
    .trst_n  (trst_n),
    .state   (state),
    .tdi     (tdi),
    .sel_id  (flags.idcode),
    .sel_byp (flags.bypass),
    .sel_bsr (sel_bsr),
    .ir_so   (ir_so),
    .bsr_so  (bsr_so),
    .tdo     (tdo),
    .tdo_en  (tdo_en)
  );

  assign sel_bsr      = flags.extest | flags.sample | flags.samplez;
  assign inst_extest  = flags.extest;
  assign inst_sample  = flags.sample;
  assign inst_samplez = flags.samplez;
  assign inst_idcode  = flags.idcode;
  assign inst_bypass  = flags.bypass;
  assign out_bus_en   = ~flags.samplez;

  assign capture_dr = (state == ST_CAP_DR);
  assign shift_dr   = (state == ST_SH_DR);
  assign update_dr  = (state == ST_UPD_DR);

  // R8
  bus_release_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $fell(out_bus_en) |-> $past(state) == ST_UPD_IR);

  // R1
  reset_idcode_chk: assert property (@(posedge tck) disable iff (!trst_n)
    $past(state) == ST_RESET |-> (inst_idcode && out_bus_en));

endmodule

// File: tb/sim_tap_instr_ctrl.sv
module sim_tap_instr_ctrl;

  localparam int CLK_PERIOD = 20;
  localparam logic [31:0] ID_VAL = 32'h5A3C_96E1;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic tdi = 1'b0;
  logic bsr_so = 1'b0;
  logic tdo, tdo_en, capture_dr, shift_dr, update_dr, sel_bsr;
  logic inst_extest, inst_sample, inst_samplez, inst_idcode, inst_bypass, out_bus_en;

  int checks = 0;
  int errors = 0;
  logic tdo_rise;
  logic upd_oe;
  logic upd_samplez;

  always #(CLK_PERIOD/2) tck = ~tck;

  tap_instr_ctrl #(.ID_W(32), .ID_VALUE(ID_VAL)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .bsr_so(bsr_so),
    .tdo(tdo), .tdo_en(tdo_en), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .sel_bsr(sel_bsr), .inst_extest(inst_extest),
    .inst_sample(inst_sample), .inst_samplez(inst_samplez),
    .inst_idcode(inst_idcode), .inst_bypass(inst_bypass), .out_bus_en(out_bus_en)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // apply inputs, pass a rising edge then a falling edge, sample just after
  task automatic step(input logic m, input logic d);
    tms = m;
    tdi = d;
    @(posedge tck);
    #1 tdo_rise = tdo;
    @(negedge tck);
    #1;
  endtask

  // from Run-Test/Idle back to Run-Test/Idle
  task automatic scan_ir(input logic [2:0] code, output logic [2:0] got);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    got[0] = tdo;
    for (int i = 0; i < 3; i++) begin
      step(i == 2, code[i]);
      if (i < 2) got[i+1] = tdo;
    end
    step(1, 0);
    upd_oe = out_bus_en;
    upd_samplez = inst_samplez;
    step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    logic prev;
    dout = '0;
    step(1, 0); step(0, 0);
    chk("R11 capture_dr", {63'b0, capture_dr}, 64'd1);
    step(0, 0);
    chk("R11 shift_dr", {63'b0, shift_dr}, 64'd1);
    chk("R10 tdo_en in shift", {63'b0, tdo_en}, 64'd1);
    dout[0] = tdo;
    for (int i = 0; i < n; i++) begin
      prev = tdo;
      step(i == n - 1, din[i]);
      if (i == 0) chk("R10 tdo stable at rise", {63'b0, tdo_rise}, {63'b0, prev});
      if (i < n - 1) dout[i+1] = tdo;
    end
    step(1, 0);
    chk("R11 update_dr", {63'b0, update_dr}, 64'd1);
    step(0, 0);
    chk("R10 tdo_en idle", {63'b0, tdo_en}, 64'd0);
  endtask

  task automatic t_reset();
    logic [2:0] got;
    trst_n = 0;
    #(CLK_PERIOD * 3);
    chk("R1 idcode in reset", {63'b0, inst_idcode}, 64'd1);
    chk("R1 bus enabled in reset", {63'b0, out_bus_en}, 64'd1);
    chk("R1 tdo_en low in reset", {63'b0, tdo_en}, 64'd0);
    @(negedge tck);
    trst_n = 1;
    step(0, 0);
    chk("R1 idcode after release", {63'b0, inst_idcode}, 64'd1);
    scan_ir(3'b111, got);
    chk("R3 IR capture pattern", {61'b0, got}, 64'd1);
    chk("R6 bypass loaded", {63'b0, inst_bypass}, 64'd1);
  endtask

  task automatic t_idcode();
    logic [2:0] got;
    logic [63:0] dout;
    scan_ir(3'b001, got);
    chk("R5 idcode flag", {63'b0, inst_idcode}, 64'd1);
    scan_dr(32, 64'h0, dout);
    chk("R5 id value", dout, {32'b0, ID_VAL});
    chk("R5 id lsb", {63'b0, dout[0]}, 64'd1);
  endtask

  task automatic t_bypass();
    logic [2:0] got;
    logic [63:0] dout;
    logic [7:0] pat = 8'b1011_0010;
    scan_ir(3'b111, got);
    scan_dr(8, {56'b0, pat}, dout);
    chk("R6 bypass one stage delay", dout, {56'b0, pat[6:0], 1'b0});
  endtask

  task automatic t_reserved();
    logic [2:0] got;
    logic [63:0] dout;
    logic [2:0] codes [3] = '{3'b011, 3'b101, 3'b110};
    for (int k = 0; k < 3; k++) begin
      scan_ir(codes[k], got);
      chk("R7 reserved flag", {63'b0, inst_bypass}, 64'd1);
      chk("R7 reserved no bsr", {63'b0, sel_bsr}, 64'd0);
      scan_dr(4, 64'hD, dout);
      chk("R7 reserved as bypass", dout, 64'hA);
    end
  endtask

  task automatic t_samplez();
    logic [2:0] got;
    logic [63:0] dout;
    scan_ir(3'b010, got);
    chk("R4 bus held until update", {63'b0, upd_oe}, 64'd1);
    chk("R4 flag held until update", {63'b0, upd_samplez}, 64'd0);
    chk("R8 bus released", {63'b0, out_bus_en}, 64'd0);
    chk("R8 samplez flag", {63'b0, inst_samplez}, 64'd1);
    chk("R8 bsr selected", {63'b0, sel_bsr}, 64'd1);
    bsr_so = 1;
    scan_dr(6, 64'h0, dout);
    chk("R8 tdo follows chain", dout, 64'h3F);
    chk("R8 bus still released", {63'b0, out_bus_en}, 64'd0);
    bsr_so = 0;
    scan_ir(3'b000, got);
    chk("R9 extest flag", {63'b0, inst_extest}, 64'd1);
    chk("R9 extest bsr", {63'b0, sel_bsr}, 64'd1);
    chk("R9 extest bus enabled", {63'b0, out_bus_en}, 64'd1);
  endtask

  task automatic t_sample();
    logic [2:0] got;
    logic [63:0] dout;
    scan_ir(3'b100, got);
    chk("R9 sample flag", {63'b0, inst_sample}, 64'd1);
    chk("R9 sample bsr", {63'b0, sel_bsr}, 64'd1);
    chk("R9 sample bus enabled", {63'b0, out_bus_en}, 64'd1);
    bsr_so = 0;
    scan_dr(4, 64'hF, dout);
    chk("R9 sample tdo from chain", dout, 64'h0);
  endtask

  task automatic t_tms_reset();
    logic [2:0] got;
    scan_ir(3'b010, got);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 4; i++) step(1, 0);
    chk("R2 four ones not reset", {63'b0, inst_samplez}, 64'd1);
    step(1, 0);
    step(0, 0);
    chk("R2 idcode after five ones", {63'b0, inst_idcode}, 64'd1);
    chk("R1 bus enabled after reset state", {63'b0, out_bus_en}, 64'd1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_idcode();
    t_bypass();
    t_reserved();
    t_samplez();
    t_sample();
    t_tms_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule